// File: doc/BRIEF.md
# Packet Head/Tail Splitter

This block sits at the entry of a forwarding pipeline. Packets arrive as a stream of 32-byte beats, framed by start and end markers and tagged with a one-bit priority from an upstream classifier. A packet of up to 224 bytes goes whole to the lookup port. A longer packet goes out in two pieces. Its first 192 bytes form a head that goes to the lookup port. The rest forms a tail that goes to the buffer-write port.

The length is not known until the end marker arrives. For this reason the block holds up to seven beats in a staging store before it decides what to do. Every packet receives an 8-bit reorder tag, whether it is cut or not, so that a later stage can rejoin head and tail. A downstream reorder block reports how many tags are still free. When that count is zero, no new packet is admitted.

Top module: `pkt_head_split`

## Requirements
- R1: A packet of L <= 224 bytes leaves on the lookup port as ceil(L/32) beats. `lk_sop` is set on the first beat and `lk_eop` on the last. `lk_cut` is 0, `lk_bytes` on the last beat is L - 32*(beats-1), and no tail beat is produced.
- R2: A packet of L > 224 bytes yields a head of exactly six full beats (192 bytes) on the lookup port, with `lk_cut` = 1 and `lk_eop` on the sixth beat.
- R3: Bytes from offset 192 onward leave on the tail port, in order and unchanged. `tail_first` marks the first tail beat and `tail_last` marks the final one. The lookup port and the tail port are never valid in the same cycle.
- R4: On the last tail beat, `tail_len` equals L - 192. On the first tail beat, `tail_tag` equals the tag that was sent with the head.
- R5: Tags come from an 8-bit counter that starts at 0 after reset. It advances by one for every admitted packet, cut or whole, and wraps from 255 to 0. The tag is presented on every lookup beat.
- R6: The priority bit sampled on a packet's first beat is presented as `lk_prio` on all of that packet's lookup beats.
- R7: While `tag_free` is 0, the first beat of a new packet is not accepted (`in_ready` = 0). Beats of a packet already admitted continue to be accepted.
- R8: While a lookup or tail beat is valid but not ready, it holds steady. The input is not accepted while staged beats are being sent to lookup.
- R9: After reset, `lk_valid` and `tail_valid` are 0 and `in_ready` is 1 provided `tag_free` is non-zero.
- R10: A beat that arrives outside a packet without `in_sop` is accepted and discarded. It produces no output and consumes no tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | 256 | Input beat, byte 0 in bits 7:0 |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_bytes | input | 6 | Valid bytes in the beat (1..32, meaningful on the last beat) |
| in_prio | input | 1 | Packet priority, sampled on the first beat |
| tag_free | input | 9 | Free reorder tags reported downstream |
| lk_valid | output | 1 | Lookup beat valid |
| lk_ready | input | 1 | Lookup beat accepted |
| lk_data | output | 256 | Lookup beat data |
| lk_sop | output | 1 | First lookup beat |
| lk_eop | output | 1 | Last lookup beat of the head or whole packet |
| lk_bytes | output | 6 | Valid bytes in the lookup beat |
| lk_cut | output | 1 | 1 if this is a head of a cut packet |
| lk_prio | output | 1 | Packet priority |
| lk_tag | output | 8 | Reorder tag |
| tail_valid | output | 1 | Tail beat valid |
| tail_ready | input | 1 | Tail beat accepted |
| tail_data | output | 256 | Tail beat data |
| tail_first | output | 1 | First tail beat |
| tail_last | output | 1 | Last tail beat |
| tail_tag | output | 8 | Reorder tag, valid on the first tail beat |
| tail_len | output | 16 | Total tail bytes, valid on the last tail beat |

## Verification
Some properties are checked on every cycle. The head always closes after exactly six beats, and a whole packet never exceeds seven. Tags step by one between successive lookup starts, and the first tail beat repeats the head's tag. The first beat is refused while no tag is free, the two outputs are never valid together, and a stalled lookup beat holds steady.

Other behaviour shows only in the bench scenarios:
- the exact bytes and their order on both ports;
- the last-beat byte counts and the tail length;
- the handling of the 224/225-byte boundary;
- the priority carried through;
- tag wrap after 256 packets;
- stray beats that are discarded.

// File: rtl/pkt_head_split.sv
module pkt_head_split #(
  parameter int BEAT_BYTES = 32,
  parameter int WHOLE_MAX  = 224,
  parameter int HEAD_BYTES = 192,
  parameter int TAG_W      = 8,
  parameter int LEN_W      = 16,
  localparam int DW = BEAT_BYTES * 8,
  localparam int BW = $clog2(BEAT_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [BW-1:0]    in_bytes,
  input  logic             in_prio,
  input  logic [TAG_W:0]   tag_free,
  output logic             lk_valid,
  input  logic             lk_ready,
  output logic [DW-1:0]    lk_data,
  output logic             lk_sop,
  output logic             lk_eop,
  output logic [BW-1:0]    lk_bytes,
  output logic             lk_cut,
  output logic             lk_prio,
  output logic [TAG_W-1:0] lk_tag,
  output logic             tail_valid,
  input  logic             tail_ready,
  output logic [DW-1:0]    tail_data,
  output logic             tail_first,
  output logic             tail_last,
  output logic [TAG_W-1:0] tail_tag,
  output logic [LEN_W-1:0] tail_len
);
  localparam int WB = WHOLE_MAX / BEAT_BYTES;
  localparam int HB = HEAD_BYTES / BEAT_BYTES;
  localparam int CW = $clog2(WB + 1);

  typedef enum logic [1:0] {S_FILL, S_LOOK, S_TAIL0, S_TAILP} state_t;

  state_t            st;
  logic [CW-1:0]     cnt, rd;
  logic              cut, prio;
  logic [BW-1:0]     lastb;
  logic [TAG_W-1:0]  cur_tag, nxt_tag;
  logic [LEN_W-1:0]  tacc;
  logic [DW-1:0]     stage [WB];

  wire in_fire = in_valid && in_ready;
  wire take    = (cnt != '0) || in_sop;
  wire lk_fire = lk_valid && lk_ready;
  wire tl_fire = tail_valid && tail_ready;

  assign in_ready = (st == S_FILL)  ? !(cnt == '0 && tag_free == '0) :
                    (st == S_TAILP) ? tail_ready : 1'b0;

  assign lk_valid = (st == S_LOOK);
  assign lk_data  = stage[rd];
  assign lk_sop   = (rd == '0);
  assign lk_eop   = cut ? (rd == CW'(HB - 1)) : (rd == cnt - CW'(1));
  assign lk_bytes = (!cut && lk_eop) ? lastb : BW'(BEAT_BYTES);
  assign lk_cut   = cut;
  assign lk_prio  = prio;
  assign lk_tag   = cur_tag;

  assign tail_valid = (st == S_TAIL0) || (st == S_TAILP && in_valid);
  assign tail_data  = (st == S_TAIL0) ? stage[HB] : in_data;
  assign tail_first = (st == S_TAIL0);
  assign tail_last  = (st == S_TAILP) && in_eop;
  assign tail_tag   = cur_tag;
  assign tail_len   = tail_last ? tacc + LEN_W'(in_bytes) : '0;

  always_ff @(posedge clk)
    if (st == S_FILL && in_fire && take) stage[cnt] <= in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_FILL;
      cnt     <= '0;
      rd      <= '0;
      cut     <= 1'b0;
      prio    <= 1'b0;
      lastb   <= '0;
      cur_tag <= '0;
      nxt_tag <= '0;
      tacc    <= '0;
    end else begin
      case (st)
        S_FILL: if (in_fire && take) begin
          if (cnt == '0) begin
            cur_tag <= nxt_tag;
            nxt_tag <= nxt_tag + 1'b1;
            prio    <= in_prio;
          end
          cnt <= cnt + CW'(1);
          rd  <= '0;
          if (in_eop) begin
            lastb <= in_bytes;
            cut   <= 1'b0;
            st    <= S_LOOK;
          end else if (cnt == CW'(WB - 1)) begin
            cut <= 1'b1;
            st  <= S_LOOK;
          end
        end
        S_LOOK: if (lk_fire) begin
          if (lk_eop) begin
            st <= cut ? S_TAIL0 : S_FILL;
            if (!cut) cnt <= '0;
          end else begin
            rd <= rd + CW'(1);
          end
        end
        S_TAIL0: if (tl_fire) begin
          tacc <= LEN_W'(BEAT_BYTES);
          st   <= S_TAILP;
        end
        S_TAILP: if (tl_fire) begin
          tacc <= tacc + LEN_W'(BEAT_BYTES);
          if (in_eop) begin
            st  <= S_FILL;
            cnt <= '0;
          end
        end
        default: st <= S_FILL;
      endcase
    end
  end
endmodule

// File: rtl/pkt_head_split_chk.sv
module pkt_head_split_chk #(
  parameter int TAG_W = 8,
  parameter int DW    = 256,
  parameter int WB    = 7,
  parameter int HB    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_sop,
  input logic             in_eop,
  input logic [TAG_W:0]   tag_free,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic [DW-1:0]    lk_data,
  input logic             lk_sop,
  input logic             lk_eop,
  input logic             lk_cut,
  input logic [TAG_W-1:0] lk_tag,
  input logic             tail_valid,
  input logic             tail_first,
  input logic [TAG_W-1:0] tail_tag
);
  logic             in_pkt, have_tag;
  logic [7:0]       lk_cnt;
  logic [TAG_W-1:0] last_tag;

  wire in_fire = in_valid && in_ready;
  wire lk_fire = lk_valid && lk_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt   <= 1'b0;
      have_tag <= 1'b0;
      lk_cnt   <= '0;
      last_tag <= '0;
    end else begin
      if (in_fire) in_pkt <= (in_sop || in_pkt) && !in_eop;
      if (lk_fire) lk_cnt <= lk_eop ? 8'd0 : lk_cnt + 8'd1;
      if (lk_fire && lk_sop) begin
        last_tag <= lk_tag;
        have_tag <= 1'b1;
      end
    end
  end

  AST_WHOLE_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire && lk_eop && !lk_cut |-> lk_cnt <= 8'(WB - 1)); // R1
  AST_HEAD_SIX: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire && lk_eop && lk_cut |-> lk_cnt == 8'(HB - 1)); // R2
  AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_valid && tail_valid)); // R3
  AST_TAIL_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    tail_valid && tail_first |-> have_tag && tail_tag == last_tag); // R4
  AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire && lk_sop && have_tag |-> lk_tag == last_tag + 1'b1); // R5
  AST_NO_FREE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    !in_pkt && tag_free == '0 |-> !in_ready); // R7
  AST_LK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !lk_ready |=> lk_valid && $stable(lk_data) && $stable(lk_eop)); // R8
endmodule

bind pkt_head_split pkt_head_split_chk #(
  .TAG_W(TAG_W), .DW(DW), .WB(WHOLE_MAX / BEAT_BYTES), .HB(HEAD_BYTES / BEAT_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sop(in_sop), .in_eop(in_eop), .tag_free(tag_free),
  .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_data(lk_data), .lk_sop(lk_sop),
  .lk_eop(lk_eop), .lk_cut(lk_cut), .lk_tag(lk_tag),
  .tail_valid(tail_valid), .tail_first(tail_first), .tail_tag(tail_tag)
);

// File: tb/tb_pkt_head_split.sv
module tb_pkt_head_split;
  localparam int CLK_PERIOD = 10;
  localparam int FREE = 8;
  localparam int NV = 10;
  localparam int T_LEN  [NV] = '{1, 32, 33, 200, 224, 225, 256, 300, 449, 1000};
  localparam int T_PRIO [NV] = '{0, 1, 0, 1, 1, 0, 1, 0, 1, 0};
  localparam int T_CUT  [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 1, 1};
  localparam int T_TLEN [NV] = '{0, 0, 0, 0, 0, 33, 64, 108, 257, 808};

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sop = 0, in_eop = 0, in_prio = 0;
  logic [255:0] in_data = '0;
  logic [5:0] in_bytes = '0;
  logic [8:0] tag_free = 9'(FREE);
  logic lk_ready = 1, tail_ready = 1, bp = 0;
  logic in_ready, lk_valid, lk_sop, lk_eop, lk_cut, lk_prio;
  logic [255:0] lk_data, tail_data;
  logic [5:0] lk_bytes;
  logic [7:0] lk_tag, tail_tag;
  logic tail_valid, tail_first, tail_last;
  logic [15:0] tail_len;
  int checks = 0, errors = 0, pcount = 0;

  pkt_head_split dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) begin
    lk_ready   <= bp ? ~lk_ready : 1'b1;
    tail_ready <= bp ? ~tail_ready : 1'b1;
  end

  task automatic chk(bit ok, string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] mk(int p, int b);
    logic [255:0] d;
    for (int j = 0; j < 32; j++) d[j*8 +: 8] = 8'(p * 7 + b * 32 + j);
    return d;
  endfunction

  task automatic send(int len, bit prio, int pid, int hold, bit drop);
    int n = (len + 31) / 32;
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      if (b == 1 && drop) tag_free = '0;
      in_valid = 1; in_data = mk(pid, b); in_sop = (b == 0); in_eop = (b == n - 1);
      in_bytes = (b == n - 1) ? 6'(len - 32 * (n - 1)) : 6'd32; in_prio = prio;
      if (b == 0 && hold > 0) begin
        tag_free = '0;
        for (int k = 0; k < hold; k++) begin
          #1 chk(!in_ready && !lk_valid, "R7 first beat held", in_ready, 0);
          @(negedge clk);
        end
        tag_free = 9'(FREE);
      end
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0; tag_free = 9'(FREE);
  endtask

  task automatic collect(int len, bit prio, int pid, bit ecut, int etlen);
    int n = (len + 31) / 32;
    int nl = ecut ? 6 : n;
    int idx = 0, t = 0;
    bit done = 0;
    while (!done) begin
      @(negedge clk); #2;
      if (lk_valid) chk(!in_ready, "R8 input held during lookup drain", in_ready, 0);
      if (lk_valid && lk_ready) begin
        chk(lk_data == mk(pid, idx), ecut ? "R2 head data" : "R1 whole data", lk_data, mk(pid, idx));
        chk(lk_sop == (idx == 0), "R1 sop position", lk_sop, idx == 0);
        chk(lk_tag == 8'(pid), "R5 tag", lk_tag, 8'(pid));
        chk(lk_prio == prio, "R6 priority", lk_prio, prio);
        chk(lk_cut == ecut, "R2 cut flag", lk_cut, ecut);
        if (lk_eop) begin
          chk(idx == nl - 1, ecut ? "R2 head beats" : "R1 whole beats", idx + 1, nl);
          chk(lk_bytes == 6'(ecut ? 32 : len - 32 * (n - 1)), "R1 last byte count", lk_bytes,
              ecut ? 32 : len - 32 * (n - 1));
          done = 1;
        end
        idx++;
      end
    end
    if (!ecut) begin
      for (int k = 0; k < 2; k++) begin
        @(negedge clk); #2;
        chk(!tail_valid, "R1 no tail for whole packet", tail_valid, 0);
      end
      return;
    end
    done = 0;
    while (!done) begin
      @(negedge clk); #2;
      if (tail_valid && tail_ready) begin
        chk(tail_data == mk(pid, 6 + t), "R3 tail data", tail_data, mk(pid, 6 + t));
        chk(tail_first == (t == 0), "R3 tail first", tail_first, t == 0);
        if (t == 0) chk(tail_tag == 8'(pid), "R4 tail tag", tail_tag, 8'(pid));
        chk(tail_last == (6 + t == n - 1), "R3 tail last", tail_last, 6 + t == n - 1);
        if (tail_last) begin
          chk(tail_len == 16'(etlen), "R4 tail length", tail_len, etlen);
          chk(tail_len == 16'(len - 192), "R4 tail length from L", tail_len, len - 192);
          done = 1;
        end
        t++;
      end
    end
  endtask

  task automatic run_pkt(int len, bit prio, bit ecut, int etlen, int hold, bit drop);
    int pid = pcount;
    pcount++;
    fork
      send(len, prio, pid, hold, drop);
      collect(len, prio, pid & 255, ecut, etlen);
    join
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(!lk_valid && !tail_valid, "R9 outputs idle in reset", {lk_valid, tail_valid}, 0);
    rst_n = 1;
    @(negedge clk); #2;
    chk(in_ready && !lk_valid && !tail_valid, "R9 reset state", {in_ready, lk_valid, tail_valid}, 3'b100);

    for (int pass = 0; pass < 2; pass++) begin
      bp = (pass == 1);
      for (int v = 0; v < NV; v++)
        run_pkt(T_LEN[v], T_PRIO[v] != 0, T_CUT[v] != 0, T_TLEN[v], 0, 0);
    end
    bp = 0;

    run_pkt(100, 1, 0, 0, 3, 0);
    run_pkt(300, 0, 1, 108, 0, 1);

    @(negedge clk);
    in_valid = 1; in_sop = 0; in_eop = 1; in_bytes = 6'd32; in_data = '1;
    #1 chk(in_ready, "R10 stray beat accepted", in_ready, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (k == 0) in_valid = 0;
      #2 chk(!lk_valid && !tail_valid, "R10 stray beat discarded", {lk_valid, tail_valid}, 0);
    end
    run_pkt(64, 1, 0, 0, 0, 0);

    while (pcount < 260) run_pkt(40, pcount[0], 0, 0, 0, 0);
    run_pkt(230, 1, 1, 38, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule